// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display, along with the current pixel and line position. It runs on one pixel clock that comes from outside the block. A 32-bit synchronous register port sets the frame geometry, the two sync polarities, a master timing switch, a plane switch and the polarity of the clock that goes to the panel.

Geometry is written as four words, two per axis. Totals, last visible indices and sync start positions are stored minus one, so they are 0-based counter values. Sync widths are stored as plain counts. Geometry writes land in a shadow bank. The counters use a separate active bank, which is loaded at the first pixel of each frame, so no frame ever mixes old and new geometry. Turning the plane on or off takes effect only at the next vertical sync. Until then, reading the control word shows the plane state that is still in force.

Every output is registered. The position outputs show the counter value from one clock earlier, and the sync and data-enable outputs describe that same position.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset all registers read 0. Timing is off, both sync outputs are 1 (inactive for active-low), data enable is 0, both position outputs are 0 and `rd_data` is 0.
- R2: Address 1 holds the horizontal total minus one in bits [16+:CW] and the last visible pixel index in bits [0+:CW]. Address 3 holds the same two fields in lines. The pixel count runs from 0 up to the total field and then wraps to 0. The line count advances on each pixel wrap and wraps to 0 after its own total field.
- R3: Address 2 holds the horizontal sync width in pixels in bits [16+:CW] and the index of the first sync pixel in bits [0+:CW]. Horizontal sync is active while the pixel count is at least the start value and below start plus width.
- R4: Address 4 uses the same layout as address 2, in lines. Vertical sync is active for the whole of every line whose count lies in [start, start+height).
- R5: Control word (address 0) bit 2 sets the horizontal sync polarity and bit 3 sets the vertical sync polarity, with 1 meaning active-high. A polarity change takes effect on the next clock.
- R6: Data enable is 1 only when the pixel count is at or below the last visible pixel index, the line count is at or below the last visible line index, and the plane is on.
- R7: Control bit 1 requests the plane state. While timing runs, a new request takes effect when the counters reach pixel 0 of the first vertical-sync line. Control-word readback bit 1 shows the plane state currently in force. While timing is off, the request takes effect on the next clock.
- R8: Writes to addresses 1 to 4 take effect at the first pixel of the following frame, or at once while timing is off.
- R9: Control bit 0 enables timing. While it is 0, both counters are held at 0, both syncs sit at their inactive level and data enable is 0.
- R10: Control bit 4 set to 1 inverts `panel_clk_o` relative to `clk`.
- R11: A read strobe returns the addressed word on `rd_data` one clock later. Geometry words read back as written. Unmapped addresses read 0. `rd_data` holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register word address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data, valid one clock after `rd_en` |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 2 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 3 |
| de_o | output | 1 | Data enable |
| hcnt_o | output | CW | Pixel position of the current outputs |
| vcnt_o | output | CW | Line position of the current outputs |
| panel_clk_o | output | 1 | Pixel clock to the panel, optionally inverted |

## Verification
The bench builds the block with its default parameters: CW = 12, DW = 32 and AW = 3. It programs small frames, 20 by 10 and then 16 by 8. With frames that small, each frame wrap, each plane hand-off at vertical sync and each geometry swap at a frame boundary happens within a few hundred clocks. A cycle-counting reference model runs alongside the design and predicts every position, sync and enable value. Directed counts of sync and enable pulses per line and per frame back up that model.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // Register word addresses
  localparam int ADR_CTRL  = 0;
  localparam int ADR_HGEOM = 1;
  localparam int ADR_HSYNC = 2;
  localparam int ADR_VGEOM = 3;
  localparam int ADR_VSYNC = 4;
  // Control word bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_PLANE = 1;
  localparam int CB_HPOL  = 2;
  localparam int CB_VPOL  = 3;
  localparam int CB_CKINV = 4;
  // Lower bit of the upper field in geometry and sync words
  localparam int HI_LSB = 16;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          plane_now,
  output logic [DW-1:0] rd_data,
  output logic          ten,
  output logic          plane_req,
  output logic          hpol,
  output logic          vpol,
  output logic          ckinv,
  output logic [CW-1:0] h_tot,
  output logic [CW-1:0] h_last,
  output logic [CW-1:0] h_start,
  output logic [CW-1:0] h_len,
  output logic [CW-1:0] v_tot,
  output logic [CW-1:0] v_last,
  output logic [CW-1:0] v_start,
  output logic [CW-1:0] v_len
);
  logic unused_wbits;
  assign unused_wbits = ^wr_data;

  function automatic logic [DW-1:0] pack2(input logic [CW-1:0] hi, input logic [CW-1:0] lo);
    logic [DW-1:0] w;
    w = '0;
    w[HI_LSB +: CW] = hi;
    w[0 +: CW] = lo;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      {ten, plane_req, hpol, vpol, ckinv} <= '0;
      {h_tot, h_last, h_start, h_len} <= '0;
      {v_tot, v_last, v_start, v_len} <= '0;
    end else if (wr_en) begin
      case (addr)
        AW'(ADR_CTRL): begin
          ten       <= wr_data[CB_RUN];
          plane_req <= wr_data[CB_PLANE];
          hpol      <= wr_data[CB_HPOL];
          vpol      <= wr_data[CB_VPOL];
          ckinv     <= wr_data[CB_CKINV];
        end
        AW'(ADR_HGEOM): begin h_tot <= wr_data[HI_LSB +: CW]; h_last  <= wr_data[0 +: CW]; end
        AW'(ADR_HSYNC): begin h_len <= wr_data[HI_LSB +: CW]; h_start <= wr_data[0 +: CW]; end
        AW'(ADR_VGEOM): begin v_tot <= wr_data[HI_LSB +: CW]; v_last  <= wr_data[0 +: CW]; end
        AW'(ADR_VSYNC): begin v_len <= wr_data[HI_LSB +: CW]; v_start <= wr_data[0 +: CW]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        AW'(ADR_CTRL): begin
          rd_data <= '0;
          rd_data[CB_RUN]   <= ten;
          rd_data[CB_PLANE] <= plane_now;
          rd_data[CB_HPOL]  <= hpol;
          rd_data[CB_VPOL]  <= vpol;
          rd_data[CB_CKINV] <= ckinv;
        end
        AW'(ADR_HGEOM): rd_data <= pack2(h_tot, h_last);
        AW'(ADR_HSYNC): rd_data <= pack2(h_len, h_start);
        AW'(ADR_VGEOM): rd_data <= pack2(v_tot, v_last);
        AW'(ADR_VSYNC): rd_data <= pack2(v_len, v_start);
        default:        rd_data <= '0;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rd_data)); // R11
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] tot,
  input  logic [CW-1:0] last,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] cnt,
  output logic          at_end,
  output logic          vis,
  output logic          in_sync
);
  logic [CW:0] sync_stop;

  assign at_end    = (cnt == tot);
  assign vis       = (cnt <= last);
  assign sync_stop = {1'b0, start} + {1'b0, len};
  assign in_sync   = (cnt >= start) && ({1'b0, cnt} < sync_stop);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (step)    cnt <= at_end ? '0 : cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= tot); // R2
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] hcnt_o,
  output logic [CW-1:0] vcnt_o,
  output logic          panel_clk_o
);
  localparam int NF = 8;

  logic ten, plane_req, hpol, vpol, ckinv, plane_act;
  logic [CW-1:0] s_ht, s_hl, s_hs, s_hw, s_vt, s_vl, s_vs, s_vw;
  logic [CW-1:0] a_ht, a_hl, a_hs, a_hw, a_vt, a_vl, a_vs, a_vw;
  logic [NF*CW-1:0] shadow_bank, act_bank;
  logic [CW-1:0] h_cnt, v_cnt;
  logic h_end, v_end, h_vis, v_vis, h_sync, v_sync;
  logic frame_end, vs_hit;

  rtg_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .plane_now(plane_act), .rd_data(rd_data),
    .ten(ten), .plane_req(plane_req), .hpol(hpol), .vpol(vpol), .ckinv(ckinv),
    .h_tot(s_ht), .h_last(s_hl), .h_start(s_hs), .h_len(s_hw),
    .v_tot(s_vt), .v_last(s_vl), .v_start(s_vs), .v_len(s_vw)
  );

  // Shadow geometry is copied into the active bank at frame wrap, or continuously while idle
  assign shadow_bank = {s_ht, s_hl, s_hs, s_hw, s_vt, s_vl, s_vs, s_vw};
  assign {a_ht, a_hl, a_hs, a_hw, a_vt, a_vl, a_vs, a_vw} = act_bank;
  assign frame_end = ten && h_end && v_end;

  always_ff @(posedge clk) begin
    if (rst)                     act_bank <= '0;
    else if (!ten || frame_end)  act_bank <= shadow_bank;
  end

  rtg_axis #(.CW(CW)) u_hax (
    .clk(clk), .rst(rst), .run(ten), .step(1'b1),
    .tot(a_ht), .last(a_hl), .start(a_hs), .len(a_hw),
    .cnt(h_cnt), .at_end(h_end), .vis(h_vis), .in_sync(h_sync)
  );

  rtg_axis #(.CW(CW)) u_vax (
    .clk(clk), .rst(rst), .run(ten), .step(h_end),
    .tot(a_vt), .last(a_vl), .start(a_vs), .len(a_vw),
    .cnt(v_cnt), .at_end(v_end), .vis(v_vis), .in_sync(v_sync)
  );

  // Plane request is honoured at pixel 0 of the first vertical-sync line
  assign vs_hit = ten && (h_cnt == '0) && (v_cnt == a_vs);

  always_ff @(posedge clk) begin
    if (rst)                  plane_act <= 1'b0;
    else if (!ten || vs_hit)  plane_act <= plane_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      de_o    <= 1'b0;
      hcnt_o  <= '0;
      vcnt_o  <= '0;
    end else begin
      hsync_o <= (ten && h_sync) ? hpol : ~hpol;
      vsync_o <= (ten && v_sync) ? vpol : ~vpol;
      de_o    <= ten && plane_act && h_vis && v_vis;
      hcnt_o  <= h_cnt;
      vcnt_o  <= v_cnt;
    end
  end

  assign panel_clk_o = clk ^ ckinv;

  AST_IDLE_NO_DE:      assert property (@(posedge clk) disable iff (rst) !ten |=> !de_o); // R9
  AST_IDLE_POS_ZERO:   assert property (@(posedge clk) disable iff (rst)
                         (!ten && !$past(ten)) |=> (hcnt_o == '0 && vcnt_o == '0)); // R9
  AST_PLANE_AT_VSYNC:  assert property (@(posedge clk) disable iff (rst)
                         (ten && $past(ten) && (plane_act != $past(plane_act)))
                         |-> ($past(h_cnt) == '0 && $past(v_cnt) == $past(a_vs))); // R7
  AST_BANK_AT_WRAP:    assert property (@(posedge clk) disable iff (rst)
                         (ten && $past(ten) && (act_bank != $past(act_bank)))
                         |-> (h_cnt == '0 && v_cnt == '0)); // R8
endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int CW = 12;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic hsync_o, vsync_o, de_o, panel_clk_o;
  logic [CW-1:0] hcnt_o, vcnt_o;

  raster_timing_gen #(.CW(CW), .DW(DW), .AW(AW)) u_raster_timing_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .hcnt_o(hcnt_o), .vcnt_o(vcnt_o), .panel_clk_o(panel_clk_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { bit rst_item; int h; int v; bit hs; bit vs; bit de; } exp_t;
  exp_t sb_q[$];

  // Cycle-counting reference model: pushes one expected output set per clock
  logic [31:0] m_reg [0:4];
  int mh, mv;
  bit m_plane;
  int a_ht, a_hl, a_hs, a_hw, a_vt, a_vl, a_vs, a_vw;

  function automatic int fhi(input logic [31:0] w); return int'(w[16 +: CW]); endfunction
  function automatic int flo(input logic [31:0] w); return int'(w[0 +: CW]); endfunction

  task automatic load_active();
    a_ht = fhi(m_reg[1]); a_hl = flo(m_reg[1]);
    a_hw = fhi(m_reg[2]); a_hs = flo(m_reg[2]);
    a_vt = fhi(m_reg[3]); a_vl = flo(m_reg[3]);
    a_vw = fhi(m_reg[4]); a_vs = flo(m_reg[4]);
  endtask

  always @(posedge clk) begin : ref_model
    exp_t it;
    bit en, fe;
    if (rst) begin
      it = '{1'b1, 0, 0, 1'b1, 1'b1, 1'b0};
      sb_q.push_back(it);
      mh = 0; mv = 0; m_plane = 0;
      for (int i = 0; i < 5; i++) m_reg[i] = '0;
      load_active();
    end else begin
      en = m_reg[0][0];
      it.rst_item = 1'b0;
      it.h  = mh;
      it.v  = mv;
      it.hs = (en && mh >= a_hs && mh < a_hs + a_hw) ? m_reg[0][2] : !m_reg[0][2];
      it.vs = (en && mv >= a_vs && mv < a_vs + a_vw) ? m_reg[0][3] : !m_reg[0][3];
      it.de = en && m_plane && (mh <= a_hl) && (mv <= a_vl);
      sb_q.push_back(it);
      if (!en) begin
        mh = 0; mv = 0;
        load_active();
        m_plane = m_reg[0][1];
      end else begin
        fe = (mh == a_ht) && (mv == a_vt);
        if (mh == 0 && mv == a_vs) m_plane = m_reg[0][1];
        if (mh == a_ht) begin
          mh = 0;
          mv = (mv == a_vt) ? 0 : mv + 1;
        end else begin
          mh = mh + 1;
        end
        if (fe) load_active();
      end
      if (wr_en && addr <= 4) m_reg[addr] = wr_data;
    end
  end

  always @(negedge clk) begin : sb_monitor
    exp_t it;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      if (it.rst_item) begin
        check("R1", "hsync in reset", hsync_o, 1);
        check("R1", "vsync in reset", vsync_o, 1);
        check("R1", "de in reset", de_o, 0);
        check("R1", "pixel pos in reset", hcnt_o, 0);
        check("R1", "line pos in reset", vcnt_o, 0);
      end else begin
        check("R2", "pixel pos", hcnt_o, it.h);
        check("R2", "line pos", vcnt_o, it.v);
        check("R3", "hsync", hsync_o, it.hs);
        check("R4", "vsync", vsync_o, it.vs);
        check("R6", "de", de_o, it.de);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  localparam logic [31:0] HG_A = (32'd19 << 16) | 32'd13;
  localparam logic [31:0] HS_A = (32'd3 << 16) | 32'd15;
  localparam logic [31:0] VG_A = (32'd9 << 16) | 32'd6;
  localparam logic [31:0] VS_A = (32'd2 << 16) | 32'd7;
  localparam logic [31:0] HG_B = (32'd15 << 16) | 32'd9;
  localparam logic [31:0] HS_B = (32'd2 << 16) | 32'd11;
  localparam logic [31:0] VG_B = (32'd7 << 16) | 32'd4;
  localparam logic [31:0] VS_B = (32'd1 << 16) | 32'd5;

  initial begin : driver
    logic [31:0] d;
    int cnt, cnt2, cnt3, mx;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1", "rd_data after reset", rd_data, 0);
    rd(0, d); check("R1", "ctrl word after reset", d, 0);
    rd(1, d); check("R1", "hgeom word after reset", d, 0);

    // Program geometry while idle, read back (R11)
    wr(1, HG_A); wr(2, HS_A); wr(3, VG_A); wr(4, VS_A);
    rd(1, d); check("R11", "hgeom readback", d, HG_A);
    rd(4, d); check("R11", "vsync readback", d, VS_A);
    rd(7, d); check("R11", "unmapped address", d, 0);
    @(negedge clk); check("R11", "rd_data holds", rd_data, 0);

    // Run with plane on, active-low syncs
    wr(0, 32'h3);
    repeat (400) @(negedge clk);
    do @(negedge clk); while (!(hcnt_o == 0 && vcnt_o == 1));
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (hsync_o == 1'b0) cnt++;
      @(negedge clk);
    end
    check("R3", "active-low hsync pixels per line", cnt, 3);

    // Plane off mid-frame: deferred to vsync (R7)
    do @(negedge clk); while (!(hcnt_o == 0 && vcnt_o == 2));
    wr(0, 32'h1);
    rd(0, d); check("R7", "plane still shown on before vsync", d[1], 1);
    do @(negedge clk); while (!(vcnt_o == 8));
    rd(0, d); check("R7", "plane shown off after vsync", d[1], 0);
    do @(negedge clk); while (!(hcnt_o == 0 && vcnt_o == 0));
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      if (de_o) cnt++;
      @(negedge clk);
    end
    check("R6", "de cycles in frame with plane off", cnt, 0);

    // Plane on again, both polarities active-high (R5)
    wr(0, 32'hF);
    do @(negedge clk); while (!(vcnt_o == 8));
    do @(negedge clk); while (!(hcnt_o == 0 && vcnt_o == 0));
    cnt = 0; cnt2 = 0; cnt3 = 0;
    for (int i = 0; i < 200; i++) begin
      if (de_o) cnt++;
      if (hsync_o) cnt2++;
      if (vsync_o) cnt3++;
      @(negedge clk);
    end
    check("R6", "de cycles per frame", cnt, 98);
    check("R5", "active-high hsync cycles per frame", cnt2, 30);
    check("R4", "active-high vsync cycles per frame", cnt3, 40);

    // Geometry change mid-frame: old frame completes (R8)
    do @(negedge clk); while (!(vcnt_o == 3));
    wr(1, HG_B); wr(2, HS_B); wr(3, VG_B); wr(4, VS_B);
    do @(negedge clk); while (!(hcnt_o == 0 && vcnt_o == 9));
    mx = 0;
    for (int i = 0; i < 20; i++) begin
      if (int'(hcnt_o) > mx) mx = int'(hcnt_o);
      @(negedge clk);
    end
    check("R8", "old line length kept until frame end", mx, 19);
    do @(negedge clk); while (!(hcnt_o == 0 && vcnt_o == 0));
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!(hcnt_o == 0 && vcnt_o == 0));
    check("R2", "new frame length in clocks", cnt, 128);

    // Panel clock inversion (R10)
    @(posedge clk); #1;
    check("R10", "panel clock not inverted", panel_clk_o, 1);
    wr(0, 32'h1F);
    @(posedge clk); #1;
    check("R10", "panel clock inverted", panel_clk_o, 0);

    // Timing off (R9)
    wr(0, 32'h1E);
    repeat (2) @(negedge clk);
    check("R9", "pixel pos while off", hcnt_o, 0);
    check("R9", "line pos while off", vcnt_o, 0);
    check("R9", "hsync inactive while off", hsync_o, 0);
    check("R9", "vsync inactive while off", vsync_o, 0);
    check("R9", "de low while off", de_o, 0);
    rd(0, d); check("R7", "ctrl readback while off", d, 32'h1E);
    wr(0, 32'h1C);
    @(negedge clk);
    rd(0, d); check("R7", "plane off at once while timing off", d[1], 0);

    // Restart with new geometry and active-low syncs
    wr(0, 32'h3);
    repeat (300) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule